// File: doc/BRIEF.md
# GPIO Group Interrupt and Wake Controller

This block serves one group of general-purpose input pads, up to the group size of sixteen. Each pad has its own configuration word that drives the pad's output value and output enable. The same word also selects how the received signal is turned into an event. Every pad input passes through a two-flop synchroniser and an optional inversion before it reaches the event detector. The detector can work on the level, on the rising edge, on either edge, or be switched off.

A detected event sets a sticky bit in the group interrupt status register, but only for pads the host owns. A single interrupt line is raised while any pending bit is also enabled. The same event sets a wake status bit when the pad's wake enable is set and the pad is not routed to the system control interrupt path. A single wake line reflects any pending wake bit.

Software reaches everything over a simple word-wide register port. Writes take effect on the clock edge. Reads are combinational from the current address. Both status registers clear by writing ones.

Top module: `gpio_evt_ctl`

## Requirements
- R1: Reset clears the interrupt status, interrupt enable, ownership, wake status and wake enable registers. Every pad configuration reads 0x0400_0100 at reset (event mode disabled, output driver off). Both irq_o and wake_o are low after reset.
- R2: Configuration bits 26:25 select the event mode: 0 = level, 1 = rising edge, 2 = disabled, 3 = both edges. An input change first reaches the status register on the third rising clock edge after it is applied.
- R3: Configuration bit 23 inverts the synchronised input before detection. Edge mode with inversion detects falling edges. Level mode with inversion detects a low level.
- R4: The interrupt status register is at 0x100. Writing 1 clears a bit and writing 0 leaves it unchanged. If a clear and a new event hit the same bit on the same edge, the bit ends up set.
- R5: The interrupt enable register is at 0x120 and is read-write. irq_o is high exactly when some pad has both its status bit and its enable bit set.
- R6: The host-ownership register is at 0x130, one bit per pad. A pad whose ownership bit is 0 never sets its status bit, but its input state stays readable in configuration bit 1.
- R7: Wake status is at 0x140 and clears on writing 1. Wake enable is at 0x160. An event sets the wake status only when the pad's wake enable is 1 and its configuration bit 19 (system-control routing) is 0. This does not depend on ownership. wake_o is high while any wake status bit is set.
- R8: For bit positions at or above NUM_PADS, the status, enable, ownership and wake bits read 0. Configuration words of those positions read 0 and ignore writes.
- R9: In level mode the status bit is set again on every edge while the qualified level is high, so a clear has no lasting effect while the level persists.
- R10: Configuration bit 0 drives pad_out. Bit 8 set drives pad_oe low. Bit 9 set disables the input path: bit 1 then reads 0 and no event is detected. Bit 1 is read-only.
- R11: The configuration word of pad n is at byte address 4*n. Writable bits are 26:25, 23, 19, 9, 8 and 0. Bit 1 returns the synchronised input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | NUM_PADS | Raw pad input levels |
| pad_out | output | NUM_PADS | Output drive value per pad |
| pad_oe | output | NUM_PADS | Output enable per pad |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_o | output | 1 | Combined interrupt request |
| wake_o | output | 1 | Combined wake request |

## Verification
A detected event and a software write-one-to-clear can meet on the same status bit at the same clock edge. The bench provokes this by placing the clearing write exactly two edges after the input change, so that the write lands on the edge where the synchronised edge is registered. It then expects the bit to read back as set. The bench model replays the same collision for both status registers on every clock. It also covers the case where a clear meets a persisting level, which must leave the bit set.

// File: rtl/gpio_evt_ctl.sv
module gpio_evt_ctl #(
  parameter int NUM_PADS   = 12,
  parameter int GROUP_SIZE = 16,
  parameter int ADDR_W     = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                irq_o,
  output logic                wake_o
);
  localparam int GS    = GROUP_SIZE;
  localparam int IDX_W = $clog2(GS);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'('h100);
  localparam logic [ADDR_W-1:0] A_IEN = ADDR_W'('h120);
  localparam logic [ADDR_W-1:0] A_OWN = ADDR_W'('h130);
  localparam logic [ADDR_W-1:0] A_WST = ADDR_W'('h140);
  localparam logic [ADDR_W-1:0] A_WEN = ADDR_W'('h160);
  localparam logic [31:0] CFG_RST   = 32'h0400_0100;
  localparam logic [31:0] CFG_WMASK = 32'h0688_0301;

  logic [GS-1:0]        exist, evt, rxs, sci;
  logic [GS-1:0]        sts_q, ien_q, own_q, wst_q, wen_q;
  logic [GS-1:0]        wbits, sts_clr, wst_clr;
  logic [GS-1:0][31:0]  cfg_v;
  logic [IDX_W-1:0]     idx;
  logic                 in_pads;

  assign idx     = bus_addr[IDX_W+1:2];
  assign in_pads = (bus_addr >> (IDX_W + 2)) == '0;
  assign wbits   = bus_wdata[GS-1:0] & exist;
  assign sts_clr = (bus_we && bus_addr == A_STS) ? wbits : '0;
  assign wst_clr = (bus_we && bus_addr == A_WST) ? wbits : '0;

  for (genvar i = 0; i < GS; i++) begin : g_pad
    if (i < NUM_PADS) begin : g_real
      logic        s1, s2, qp, q, hit;
      logic [31:0] c_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s1  <= 1'b0;
          s2  <= 1'b0;
          qp  <= 1'b0;
          c_q <= CFG_RST;
        end else begin
          s1 <= pad_in[i];
          s2 <= s1;
          qp <= q;
          if (bus_we && in_pads && idx == IDX_W'(i))
            c_q <= bus_wdata & CFG_WMASK;
        end
      end

      assign q = s2 ^ c_q[23];

      always_comb begin
        case (c_q[26:25])
          2'd0:    hit = q;
          2'd1:    hit = q & ~qp;
          2'd3:    hit = q ^ qp;
          default: hit = 1'b0;
        endcase
      end

      assign evt[i]     = hit & ~c_q[9];
      assign rxs[i]     = s2 & ~c_q[9];
      assign sci[i]     = c_q[19];
      assign exist[i]   = 1'b1;
      assign cfg_v[i]   = c_q;
      assign pad_out[i] = c_q[0];
      assign pad_oe[i]  = ~c_q[8];
    end else begin : g_none
      assign evt[i]   = 1'b0;
      assign rxs[i]   = 1'b0;
      assign sci[i]   = 1'b0;
      assign exist[i] = 1'b0;
      assign cfg_v[i] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      ien_q <= '0;
      own_q <= '0;
      wst_q <= '0;
      wen_q <= '0;
    end else begin
      sts_q <= ((sts_q & ~sts_clr) | (evt & own_q)) & exist;
      wst_q <= ((wst_q & ~wst_clr) | (evt & wen_q & ~sci)) & exist;
      if (bus_we && bus_addr == A_IEN) ien_q <= wbits;
      if (bus_we && bus_addr == A_OWN) own_q <= wbits;
      if (bus_we && bus_addr == A_WEN) wen_q <= wbits;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (in_pads) bus_rdata = cfg_v[idx] | {30'd0, rxs[idx], 1'b0};
    else begin
      case (bus_addr)
        A_STS:   bus_rdata = 32'(sts_q);
        A_IEN:   bus_rdata = 32'(ien_q);
        A_OWN:   bus_rdata = 32'(own_q);
        A_WST:   bus_rdata = 32'(wst_q);
        A_WEN:   bus_rdata = 32'(wen_q);
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq_o  = |(sts_q & ien_q);
  assign wake_o = |wst_q;

  AST_STS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_STS && (bus_wdata[GS-1:0] & evt & own_q) == '0)
    |=> (sts_q & $past(bus_wdata[GS-1:0])) == '0);  // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_STS && (evt & own_q) != '0)
    |=> (sts_q & $past(evt & own_q)) == $past(evt & own_q));  // R4
  AST_NOT_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sts_q & ~$past(sts_q) & ~$past(own_q)) == '0);  // R6
  AST_WAKE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (wst_q & ~$past(wst_q) & $past(~wen_q | sci)) == '0);  // R7
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq_o);  // R5
  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_STS) |-> (bus_rdata[GS-1:0] & ~exist) == '0);  // R8
endmodule

// File: tb/gpio_evt_ctl_test.sv
`timescale 1ns/1ps
module gpio_evt_ctl_test;
  localparam int NP = 12;
  localparam int GS = 16;
  localparam logic [GS-1:0] EXIST = 16'h0FFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;
  logic          bus_we = 1'b0;
  logic [8:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq_o, wake_o;

  int    vectors = 0;
  int    errors = 0;
  bit    run = 0;
  bit    done = 0;
  string cur_req = "R1";

  gpio_evt_ctl uut (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .wake_o(wake_o)
  );

  logic [NP-1:0] m_s1 = '0, m_s2 = '0, m_qp = '0;
  logic [31:0]   m_cfg [NP];
  logic [GS-1:0] m_sts = '0, m_ien = '0, m_own = '0, m_wst = '0, m_wen = '0;

  always @(posedge clk) begin : model
    logic [GS-1:0] ev, wb, sciv;
    logic [NP-1:0] nq;
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_qp = '0;
      m_sts = '0; m_ien = '0; m_own = '0; m_wst = '0; m_wen = '0;
      for (int p = 0; p < NP; p++) m_cfg[p] = 32'h0400_0100;
    end else begin
      ev = '0; sciv = '0;
      for (int p = 0; p < NP; p++) begin
        logic qv;
        qv = m_s2[p] ^ m_cfg[p][23];
        nq[p] = qv;
        sciv[p] = m_cfg[p][19];
        if (!m_cfg[p][9]) begin
          case (m_cfg[p][26:25])
            2'd0: ev[p] = qv;
            2'd1: ev[p] = qv && !m_qp[p];
            2'd3: ev[p] = (qv != m_qp[p]);
            default: ev[p] = 1'b0;
          endcase
        end
      end
      wb = bus_wdata[GS-1:0] & EXIST;
      if (bus_we && bus_addr == 9'h100) m_sts = m_sts & ~wb;
      m_sts = m_sts | (ev & m_own);
      if (bus_we && bus_addr == 9'h140) m_wst = m_wst & ~wb;
      m_wst = m_wst | (ev & m_wen & ~sciv);
      if (bus_we && bus_addr == 9'h120) m_ien = wb;
      if (bus_we && bus_addr == 9'h130) m_own = wb;
      if (bus_we && bus_addr == 9'h160) m_wen = wb;
      if (bus_we && bus_addr < 9'd64 && int'(bus_addr[5:2]) < NP)
        m_cfg[bus_addr[5:2]] = bus_wdata & 32'h0688_0301;
      m_qp = nq; m_s2 = m_s1; m_s1 = pad_in;
    end
  end

  function automatic logic [31:0] m_read(logic [8:0] a);
    if (a < 9'd64) begin
      if (int'(a[5:2]) < NP)
        return m_cfg[a[5:2]] | {30'd0, m_s2[a[5:2]] & ~m_cfg[a[5:2]][9], 1'b0};
      return '0;
    end
    case (a)
      9'h100: return 32'(m_sts);
      9'h120: return 32'(m_ien);
      9'h130: return 32'(m_own);
      9'h140: return 32'(m_wst);
      9'h160: return 32'(m_wen);
      default: return '0;
    endcase
  endfunction

  task automatic cmp(string r, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s at %0t: got %h expected %h", r, $time, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (run && !done) begin : per_clock
      logic [NP-1:0] eo, ee;
      for (int p = 0; p < NP; p++) begin
        eo[p] = m_cfg[p][0];
        ee[p] = !m_cfg[p][8];
      end
      cmp(cur_req, bus_rdata, m_read(bus_addr));
      cmp("R5", 32'(irq_o), 32'(|(m_sts & m_ien)));
      cmp("R7", 32'(wake_o), 32'(|m_wst));
      cmp("R10", {8'd0, pad_oe, pad_out}, {8'd0, ee, eo});
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rdchk(logic [8:0] a, logic [31:0] e, string r);
    @(negedge clk); #1;
    bus_addr = a;
    #2;
    cmp(r, bus_rdata, e);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    run = 1;
    cur_req = "R1";
    rdchk(9'h000, 32'h0400_0100, "R1");
    rdchk(9'h100, 32'h0, "R1");
    rdchk(9'h120, 32'h0, "R1");
    rdchk(9'h160, 32'h0, "R1");
    cmp("R1", 32'(irq_o), 32'h0);

    cur_req = "R11";
    wr(9'h00C, 32'h0000_0001);
    rdchk(9'h00C, 32'h1, "R11");
    cmp("R10", 32'(pad_out[3]), 32'h1);
    cmp("R10", 32'(pad_oe[3]), 32'h1);
    pad_in[3] = 1'b1;
    cyc(4);
    rdchk(9'h00C, 32'h3, "R11");
    cur_req = "R6";
    rdchk(9'h100, 32'h0, "R6");
    wr(9'h130, 32'hFFFF);
    rdchk(9'h130, 32'h0FFF, "R8");
    cur_req = "R9";
    cyc(1);
    rdchk(9'h100, 32'h8, "R9");
    wr(9'h100, 32'h8);
    rdchk(9'h100, 32'h8, "R9");
    pad_in[3] = 1'b0;
    cyc(4);
    wr(9'h100, 32'h8);
    rdchk(9'h100, 32'h0, "R4");

    cur_req = "R2";
    wr(9'h014, 32'h0200_0000);
    pad_in[5] = 1'b1;
    cyc(4);
    rdchk(9'h100, 32'h20, "R2");
    cur_req = "R4";
    wr(9'h100, 32'hFFDF);
    rdchk(9'h100, 32'h20, "R4");
    cur_req = "R5";
    wr(9'h120, 32'h20);
    cmp("R5", 32'(irq_o), 32'h1);
    wr(9'h120, 32'h10);
    cmp("R5", 32'(irq_o), 32'h0);
    cur_req = "R2";
    wr(9'h100, 32'h20);
    rdchk(9'h100, 32'h0, "R2");
    pad_in[5] = 1'b0;
    cyc(4);
    rdchk(9'h100, 32'h0, "R2");

    cur_req = "R3";
    wr(9'h018, 32'h0280_0000);
    cyc(3);
    wr(9'h100, 32'hFFFF);
    rdchk(9'h100, 32'h0, "R3");
    pad_in[6] = 1'b1;
    cyc(4);
    rdchk(9'h100, 32'h0, "R3");
    pad_in[6] = 1'b0;
    cyc(4);
    rdchk(9'h100, 32'h40, "R3");
    wr(9'h100, 32'h40);
    wr(9'h01C, 32'h0080_0000);
    cyc(2);
    rdchk(9'h100, 32'h80, "R3");
    pad_in[7] = 1'b1;
    cyc(4);
    wr(9'h100, 32'h80);
    rdchk(9'h100, 32'h0, "R3");

    cur_req = "R2";
    wr(9'h020, 32'h0600_0000);
    pad_in[8] = 1'b1;
    cyc(4);
    rdchk(9'h100, 32'h100, "R2");
    wr(9'h100, 32'h100);
    pad_in[8] = 1'b0;
    cyc(4);
    rdchk(9'h100, 32'h100, "R2");
    wr(9'h100, 32'h100);
    wr(9'h024, 32'h0400_0000);
    pad_in[9] = 1'b1;
    cyc(4);
    pad_in[9] = 1'b0;
    cyc(4);
    rdchk(9'h100, 32'h0, "R2");
    rdchk(9'h024, 32'h0400_0000, "R2");

    cur_req = "R10";
    wr(9'h028, 32'h0000_0300);
    pad_in[10] = 1'b1;
    cyc(4);
    rdchk(9'h028, 32'h300, "R10");
    rdchk(9'h100, 32'h0, "R10");
    cmp("R10", 32'(pad_oe[10]), 32'h0);
    wr(9'h028, 32'h0000_0202);
    rdchk(9'h028, 32'h200, "R10");
    wr(9'h028, 32'h0400_0100);

    cur_req = "R7";
    wr(9'h160, 32'hFFFF);
    rdchk(9'h160, 32'h0FFF, "R8");
    pad_in[5] = 1'b1;
    cyc(4);
    rdchk(9'h140, 32'h20, "R7");
    cmp("R7", 32'(wake_o), 32'h1);
    wr(9'h140, 32'h20);
    rdchk(9'h140, 32'h0, "R7");
    cmp("R7", 32'(wake_o), 32'h0);
    pad_in[5] = 1'b0;
    cyc(4);
    wr(9'h014, 32'h0208_0000);
    wr(9'h100, 32'hFFFF);
    pad_in[5] = 1'b1;
    cyc(4);
    rdchk(9'h140, 32'h0, "R7");
    rdchk(9'h100, 32'h20, "R7");
    wr(9'h100, 32'hFFFF);
    pad_in[5] = 1'b0;
    cyc(4);

    cur_req = "R4";
    @(negedge clk); #1;
    pad_in[5] = 1'b1;
    @(negedge clk);
    @(negedge clk); #1;
    bus_we = 1'b1; bus_addr = 9'h100; bus_wdata = 32'h20;
    @(negedge clk); #1;
    bus_we = 1'b0;
    rdchk(9'h100, 32'h20, "R4");
    wr(9'h100, 32'h20);
    rdchk(9'h100, 32'h0, "R4");

    cur_req = "R8";
    rdchk(9'h034, 32'h0, "R8");
    wr(9'h034, 32'h0000_0001);
    rdchk(9'h034, 32'h0, "R8");
    wr(9'h120, 32'hFFFF);
    rdchk(9'h120, 32'h0FFF, "R8");
    cyc(2);

    done = 1;
    summary();
    $finish;
  end
endmodule